// File: doc/BRIEF.md
# Fully Associative Byte Cache with FIFO Replacement

This block sits between a CPU with 16-bit addresses and 8-bit data and a slower backing memory. It holds eight cached bytes. Each entry stores a valid flag and a 24-bit word made of the full address followed by the byte at that address. A lookup compares the request address against every entry at the same time. The compare is a content-addressable match whose mask covers the address field only, so the data bits never take part in a match. A read that hits is answered combinationally in the cycle it is presented. A read that misses stalls the CPU, fetches the byte over a request/acknowledge memory port, returns the byte and places it in the cache.

Writes always go to memory (write-through). A write that hits also refreshes the cached byte. A write that misses leaves the cache untouched. A single wrapping pointer chooses where each fill goes. Fills start at entry 0 and move upward one entry per fill. Once all entries hold data, each new fill therefore overwrites the entry that was loaded longest ago. Hits do not move the pointer, and neither do writes.

The CPU keeps its request steady until it sees `busy_o` low. A request completes in the cycle where `busy_o` is low while `req_valid_i` is high.

Top module: `assoc_fifo_cache`

## Requirements
- R1: After reset every entry is invalid. With no request, `busy_o`, `mem_req_o` and `rsp_hit_o` are low, and the first read of any address misses.
- R2: A read whose address is held in a valid entry drives `rsp_hit_o` high, `busy_o` low and the cached byte on `rsp_rdata_o` in the same cycle. It does not raise `mem_req_o`.
- R3: A read miss drives `busy_o` high with `rsp_hit_o` low. From the next cycle `mem_req_o` is high with `mem_write_o` low and `mem_addr_o` equal to the request address. In the cycle where `mem_ack_i` is high, `busy_o` is low and `rsp_rdata_o` equals `mem_rdata_i`.
- R4: The byte returned by a read miss is written into the cache. A later read of that address hits with that byte. At most one entry matches any address.
- R5: With 8 entries, fills go to entries 0, 1, …, 7 and then wrap to 0. When the cache is full, a fill replaces the entry loaded earliest, and the other seven entries still hit.
- R6: The replacement pointer moves only on a fill. Read hits and writes, to any entry, do not change which entry the next fill replaces.
- R7: Every write, hit or miss, drives `busy_o` high. From the next cycle `mem_req_o` and `mem_write_o` are high, with `mem_addr_o` and `mem_wdata_o` equal to the request address and data. The write completes in the cycle of `mem_ack_i`.
- R8: A write that hits also updates the cached byte when the memory acknowledges. A later read hits and returns the new byte.
- R9: A write that misses fills no entry. A later read of that address misses and fetches the byte from memory.
- R10: While `mem_req_o` is high and `mem_ack_i` is low, `mem_addr_o`, `mem_write_o` and `mem_wdata_o` hold their values. After an acknowledge, `mem_req_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | CPU request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | CPU address |
| req_wdata_i | input | 8 | CPU write data |
| busy_o | output | 1 | Request not finished this cycle; CPU holds its request |
| rsp_hit_o | output | 1 | Request address found in the cache (idle state only) |
| rsp_rdata_o | output | 8 | Read data, valid when a read completes |
| mem_req_o | output | 1 | Memory access request |
| mem_write_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_ack_i | input | 1 | Memory finished the access this cycle |
| mem_rdata_i | input | 8 | Memory read data, valid with the acknowledge |

## Verification
Once the cache is full, a read miss fills an entry and evicts the oldest one on the same clock edge. It also returns the fetched byte to the CPU in that cycle. The bench fills all eight entries and then keeps missing with new addresses. It checks that the byte returned on the acknowledge cycle is correct. It then reads the evicted address and expects a miss, and reads the seven survivors and expects hits. A queue model in the bench predicts the eviction order. To tell FIFO order apart from recency order, the bench hits the oldest entry repeatedly just before the next miss and still expects that entry to be the one replaced.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEM  = 1'b1
  } afc_state_e;
endpackage

// File: rtl/afc_tag_cam.sv
module afc_tag_cam #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  key_addr_i,
  input  logic               fill_en_i,
  input  logic [IDX_W-1:0]   fill_idx_i,
  input  logic [ADDR_W-1:0]  fill_addr_i,
  input  logic [DATA_W-1:0]  fill_data_i,
  input  logic               upd_en_i,
  input  logic [IDX_W-1:0]   upd_idx_i,
  input  logic [DATA_W-1:0]  upd_data_i,
  output logic [ENTRIES-1:0] match_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic [DATA_W-1:0]  hit_data_o
);
  localparam int ENTRY_W = ADDR_W + DATA_W;
  // compare mask: address field set, data field cleared
  localparam logic [ENTRY_W-1:0] LOOKUP_MASK = {{ADDR_W{1'b1}}, {DATA_W{1'b0}}};

  logic [ENTRY_W-1:0] key_word;
  logic [DATA_W-1:0]  data_arr [ENTRIES];

  assign key_word = {key_addr_i, {DATA_W{1'b0}}};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [ENTRY_W-1:0] word_q;
    logic               vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '0;
        vld_q  <= 1'b0;
      end else if (fill_en_i && (fill_idx_i == IDX_W'(e))) begin
        word_q <= {fill_addr_i, fill_data_i};
        vld_q  <= 1'b1;
      end else if (upd_en_i && (upd_idx_i == IDX_W'(e))) begin
        word_q[DATA_W-1:0] <= upd_data_i;
      end
    end

    assign match_o[e]  = vld_q && (((word_q ^ key_word) & LOOKUP_MASK) == '0);
    assign data_arr[e] = word_q[DATA_W-1:0];
  end

  // match vector is one-hot or empty, so OR-reduction encodes it
  always_comb begin
    hit_idx_o  = '0;
    hit_data_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match_o[e]) begin
        hit_idx_o  = hit_idx_o | IDX_W'(e);
        hit_data_o = hit_data_o | data_arr[e];
      end
    end
  end

  assign hit_o = |match_o;
endmodule

// File: rtl/afc_fifo_ptr.sv
module afc_fifo_ptr #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (advance_i) begin
      ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/afc_ctrl.sv
module afc_ctrl
  import afc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  hit_idx_i,
  input  logic [DATA_W-1:0] hit_data_i,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              fill_en_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic [DATA_W-1:0] fill_data_o,
  output logic              upd_en_o,
  output logic [IDX_W-1:0]  upd_idx_o,
  output logic [DATA_W-1:0] upd_data_o
);
  afc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic              hit_q;
  logic [IDX_W-1:0]  hit_idx_q;
  logic              need_mem;
  logic              in_idle;

  assign in_idle  = (state_q == ST_IDLE);
  assign need_mem = req_valid_i && (req_write_i || !hit_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (need_mem)  state_d = ST_MEM;
      ST_MEM:  if (mem_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
      hit_q     <= 1'b0;
      hit_idx_q <= '0;
    end else begin
      state_q <= state_d;
      if (in_idle && need_mem) begin
        addr_q    <= req_addr_i;
        wdata_q   <= req_wdata_i;
        write_q   <= req_write_i;
        hit_q     <= hit_i;
        hit_idx_q <= hit_idx_i;
      end
    end
  end

  assign busy_o      = in_idle ? need_mem : !mem_ack_i;
  assign rsp_hit_o   = in_idle && req_valid_i && hit_i;
  assign rsp_rdata_o = in_idle ? hit_data_i : mem_rdata_i;

  assign mem_req_o   = !in_idle;
  assign mem_write_o = !in_idle && write_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  // read miss fills the victim; write hit refreshes its entry
  assign fill_en_o   = !in_idle && mem_ack_i && !write_q;
  assign fill_addr_o = addr_q;
  assign fill_data_o = mem_rdata_i;
  assign upd_en_o    = !in_idle && mem_ack_i && write_q && hit_q;
  assign upd_idx_o   = hit_idx_q;
  assign upd_data_o  = wdata_q;
endmodule

// File: rtl/assoc_fifo_cache.sv
module assoc_fifo_cache #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] match_vec;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [DATA_W-1:0]  hit_data;
  logic [IDX_W-1:0]   victim_idx;
  logic               fill_en;
  logic [ADDR_W-1:0]  fill_addr;
  logic [DATA_W-1:0]  fill_data;
  logic               upd_en;
  logic [IDX_W-1:0]   upd_idx;
  logic [DATA_W-1:0]  upd_data;

  afc_tag_cam #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) u_cam (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_addr_i (req_addr_i),
    .fill_en_i  (fill_en),
    .fill_idx_i (victim_idx),
    .fill_addr_i(fill_addr),
    .fill_data_i(fill_data),
    .upd_en_i   (upd_en),
    .upd_idx_i  (upd_idx),
    .upd_data_i (upd_data),
    .match_o    (match_vec),
    .hit_o      (hit),
    .hit_idx_o  (hit_idx),
    .hit_data_o (hit_data)
  );

  afc_fifo_ptr #(
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .advance_i(fill_en),
    .ptr_o    (victim_idx)
  );

  afc_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .hit_i      (hit),
    .hit_idx_i  (hit_idx),
    .hit_data_i (hit_data),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .busy_o     (busy_o),
    .rsp_hit_o  (rsp_hit_o),
    .rsp_rdata_o(rsp_rdata_o),
    .mem_req_o  (mem_req_o),
    .mem_write_o(mem_write_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .fill_en_o  (fill_en),
    .fill_addr_o(fill_addr),
    .fill_data_o(fill_data),
    .upd_en_o   (upd_en),
    .upd_idx_o  (upd_idx),
    .upd_data_o (upd_data)
  );
endmodule

// File: rtl/afc_cache_chk.sv
module afc_cache_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_write_i,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic               busy_o,
  input logic               rsp_hit_o,
  input logic               mem_req_o,
  input logic               mem_write_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic [DATA_W-1:0]  mem_wdata_o,
  input logic               mem_ack_i,
  input logic [ENTRIES-1:0] match_i
);
  assert_hit_no_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && rsp_hit_o |-> !busy_o && !mem_req_o);

  assert_miss_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && req_valid_i && !req_write_i && !rsp_hit_o
    |=> mem_req_o && !mem_write_o && (mem_addr_o == $past(req_addr_i)));

  assert_wait_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |-> busy_o);

  assert_ack_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |-> !busy_o);

  assert_single_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_i));

  assert_write_through_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && req_valid_i && req_write_i
    |=> mem_req_o && mem_write_o && (mem_addr_o == $past(req_addr_i)));

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i
    |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_write_o) && $stable(mem_wdata_o));

  assert_req_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o);
endmodule

bind assoc_fifo_cache afc_cache_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ENTRIES(ENTRIES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .busy_o     (busy_o),
  .rsp_hit_o  (rsp_hit_o),
  .mem_req_o  (mem_req_o),
  .mem_write_o(mem_write_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ack_i  (mem_ack_i),
  .match_i    (match_vec)
);

// File: tb/assoc_fifo_cache_bench.sv
module assoc_fifo_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_ENT    = 8;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, rsp_hit, mem_req, mem_write;
  logic [7:0]  rsp_rdata, mem_wdata;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [15:0] q_addr[$];
  logic [7:0]  q_data[$];
  logic [7:0]  mem_over[int];

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_fifo_cache u_assoc_fifo_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy), .rsp_hit_o(rsp_hit), .rsp_rdata_o(rsp_rdata),
    .mem_req_o(mem_req), .mem_write_o(mem_write),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    if (mem_over.exists(int'(a))) return mem_over[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic int model_find(input logic [15:0] a);
    foreach (q_addr[i]) if (q_addr[i] == a) return i;
    return -1;
  endfunction

  task automatic mem_phase(input string tag, input int lat, input bit wr,
                           input logic [15:0] a, input logic [7:0] wd, input logic [7:0] rd);
    bit done = 0;
    for (int c = 0; c < 24 && !done; c++) begin
      @(posedge clk);
      @(negedge clk);
      check("R10", "mem_req held", {31'b0, mem_req}, 32'd1);
      check(tag, "mem_write", {31'b0, mem_write}, {31'b0, wr});
      check("R10", "mem_addr", {16'b0, mem_addr}, {16'b0, a});
      if (wr) check("R7", "mem_wdata", {24'b0, mem_wdata}, {24'b0, wd});
      if (c >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = rd;
        if (wr) mem_over[int'(a)] = wd;
        #1;
        check(tag, "busy on ack", {31'b0, busy}, 32'd0);
        if (!wr) check(tag, "rdata on ack", {24'b0, rsp_rdata}, {24'b0, rd});
        done = 1;
      end else begin
        mem_ack = 1'b0;
        #1;
        check(tag, "busy while waiting", {31'b0, busy}, 32'd1);
      end
    end
    @(posedge clk);
  endtask

  task automatic do_read(input logic [15:0] a, input int lat, input string tag);
    int idx;
    logic [7:0] d;
    @(negedge clk);
    mem_ack = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
    #1;
    idx = model_find(a);
    check(tag, "hit flag", {31'b0, rsp_hit}, {31'b0, idx >= 0});
    if (idx >= 0) begin
      check("R2", "busy on hit", {31'b0, busy}, 32'd0);
      check("R2", "hit data", {24'b0, rsp_rdata}, {24'b0, q_data[idx]});
      check("R2", "no mem_req on hit", {31'b0, mem_req}, 32'd0);
      @(posedge clk);
    end else begin
      check("R3", "busy on miss", {31'b0, busy}, 32'd1);
      d = mem_val(a);
      mem_phase("R3", lat, 1'b0, a, 8'h00, d);
      if (q_addr.size() == NUM_ENT) begin
        void'(q_addr.pop_front());
        void'(q_data.pop_front());
      end
      q_addr.push_back(a);
      q_data.push_back(d);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] wd, input int lat,
                          input string tag);
    int idx;
    @(negedge clk);
    mem_ack = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = wd;
    #1;
    idx = model_find(a);
    check(tag, "write hit flag", {31'b0, rsp_hit}, {31'b0, idx >= 0});
    check("R7", "busy on write", {31'b0, busy}, 32'd1);
    mem_phase("R7", lat, 1'b1, a, wd, 8'h00);
    if (idx >= 0) q_data[idx] = wd;
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; mem_ack = 1'b0;
    #1;
    check("R1", "idle busy", {31'b0, busy}, 32'd0);
    check("R1", "idle mem_req", {31'b0, mem_req}, 32'd0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  function automatic logic [15:0] pool(input int i);
    return 16'h1000 + 16'(i) * 16'h0111;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "reset busy", {31'b0, busy}, 32'd0);
    check("R1", "reset mem_req", {31'b0, mem_req}, 32'd0);
    check("R1", "reset hit", {31'b0, rsp_hit}, 32'd0);

    // cold fills with varied latency; first one must miss after reset
    do_read(pool(0), 0, "R1");
    for (int i = 1; i < NUM_ENT; i++) do_read(pool(i), i % 4, "R3");
    go_idle();
    // every fill now hits
    for (int i = 0; i < NUM_ENT; i++) do_read(pool(i), 1, "R4");

    // write hit then readback
    do_write(pool(2), 8'h3C, 2, "R8");
    do_read(pool(2), 0, "R8");
    // write miss does not allocate; readback fetches new byte, evicting pool(0)
    do_write(pool(9), 8'hC3, 1, "R9");
    do_read(pool(9), 1, "R9");
    do_read(pool(0), 0, "R5");
    do_read(pool(3), 0, "R5");
    do_read(pool(7), 0, "R5");

    // oldest is now pool(2): keep hitting and writing it, then miss
    do_read(pool(2), 0, "R6");
    do_read(pool(2), 0, "R6");
    do_write(pool(2), 8'h5D, 0, "R6");
    do_read(pool(10), 2, "R6");
    do_read(pool(2), 1, "R6");
    do_read(pool(4), 0, "R6");
    go_idle();

    // mixed traffic over a pool larger than the cache
    for (int n = 0; n < 400; n++) begin
      int idx;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      idx = int'(lfsr[11:8]) % 12;
      if (lfsr[3:2] == 2'b00) do_write(pool(idx), lfsr[7:0], int'(lfsr[5:4]), "R7");
      else                    do_read(pool(idx), int'(lfsr[5:4]), "R5");
      if (lfsr[1:0] == 2'b11) go_idle();
    end
    go_idle();

    finished = 1;
    report();
    $finish;
  end
endmodule